// File: doc/BRIEF.md
# Sync Activity Detector and Interface Arbiter

This block watches four incoming signals for transitions: horizontal sync, vertical sync, sync carried on the green channel, and the clock of a digital video link. Each signal gets its own activity flag. A flag is raised by an edge and dropped after a set number of reference-clock cycles pass with no edge. A signal held at a fixed level therefore never counts as active.

The four flags feed two registered decisions. The first decides whether the analog or the digital video path should be used. The analog path counts as present when any of the three sync flags is set. The digital path counts as present when the link-clock flag is set. The second decision picks which horizontal sync source drives the pixel PLL: the dedicated sync pin or sync-on-green.

Each decision has a user priority bit, which settles a tie when both candidates are present. Each also has a user force bit, which makes the result equal to the priority bit whatever the flags say. When no interface is present and the interface force bit is clear, the block raises a seek-mode power-down request.

Top module: `sync_arbiter`

## Requirements
- R1: A monitored input that holds one level for IDLE_LIMIT+8 reference cycles or longer reads 0 in its activity bit.
- R2: A level change on a monitored input sets its activity bit within 6 cycles. The bit positions in act_status_o are: [3] horizontal sync, [2] sync-on-green, [1] vertical sync, [0] link clock.
- R3: An activity bit stays 1 while edges keep arriving less than IDLE_LIMIT cycles apart. It returns to 0 once edges stop for longer than IDLE_LIMIT+2 cycles.
- R4: With if_force_i low, when any of act_status_o[3:1] is 1 and act_status_o[0] is 0, if_sel_o becomes 0 (analog) one cycle later.
- R5: With if_force_i low, when act_status_o[3:1] is 0 and act_status_o[0] is 1, if_sel_o becomes 1 (digital) one cycle later.
- R6: With if_force_i low and both interfaces present, if_sel_o one cycle later equals if_prio_i.
- R7: With if_force_i low and all four activity bits 0, seek_o is 1 one cycle later and if_sel_o keeps its value. In every other case seek_o is 0.
- R8: With if_force_i high, if_sel_o one cycle later equals if_prio_i and seek_o is 0, whatever the activity bits say.
- R9: sync_sel_o is 0 for the sync pin and 1 for sync-on-green. With src_force_i low and only one of act_status_o[3] and act_status_o[2] set, that source is selected one cycle later.
- R10: When src_force_i is high, or when both act_status_o[3] and act_status_o[2] are set, sync_sel_o one cycle later equals src_prio_i.
- R11: With src_force_i low and neither act_status_o[3] nor act_status_o[2] set, sync_sel_o keeps its value.
- R12: While rst_n is low, every output is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync pin, monitored |
| sog_i | input | 1 | Sync sliced from green, monitored |
| vsync_i | input | 1 | Vertical sync pin, monitored |
| dclk_i | input | 1 | Digital link clock, monitored |
| if_prio_i | input | 1 | Interface used when both are present (1 = digital) |
| if_force_i | input | 1 | Make interface result equal if_prio_i |
| src_prio_i | input | 1 | Sync source used when both are present (1 = sync-on-green) |
| src_force_i | input | 1 | Make sync source result equal src_prio_i |
| act_status_o | output | 4 | Activity flags: [3] hsync, [2] sog, [1] vsync, [0] link clock |
| if_sel_o | output | 1 | Active interface: 0 analog, 1 digital |
| sync_sel_o | output | 1 | PLL sync source: 0 sync pin, 1 sync-on-green |
| seek_o | output | 1 | Soft power-down (seek) request |

## Verification
The stimulus toggles each monitored input on its own: horizontal sync only, sync-on-green only, and link clock only. These runs show that each activity bit maps to the right position and that each one-sided case resolves to the correct choice. Runs with analog sync and link clock together, and with both sync sources together, repeat under each priority value. They separate tie handling by priority from a fixed default. Quiet periods with the inputs held high check the timeout and the seek request, and show that the sync choice is held and not reset. Force cases with no activity at all confirm that force takes precedence over the seek path.

// File: rtl/sync_arb_pkg.sv
// Package: shared indices and selection encoding for the sync arbiter.
// Assumes: all users index the activity vector through these constants.
package sync_arb_pkg;
    localparam int NUM_MON  = 4;
    localparam int MON_HS   = 3;
    localparam int MON_SOG  = 2;
    localparam int MON_VS   = 1;
    localparam int MON_DCLK = 0;

    typedef enum logic {
        PICK_FIRST  = 1'b0,
        PICK_SECOND = 1'b1
    } pick_e;
endpackage

// File: rtl/activity_monitor.sv
// Module: activity_monitor
// Resynchronises one asynchronous input into the reference clock and
// reports activity. An edge seen after the synchroniser sets the flag.
// The flag is cleared once IDLE_LIMIT cycles pass with no further edge.
// Assumes: the input toggles slower than half the reference rate.
module activity_monitor #(
    parameter int IDLE_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

    logic             sync_a;
    logic             sync_b;
    logic             last_lvl;
    logic [2:0]       primed;
    logic [CNT_W-1:0] idle_cnt;
    logic             edge_seen;

    // Two-flop synchroniser, a history flop, and a warm-up mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            last_lvl <= 1'b0;
            primed   <= '0;
        end else begin
            sync_a   <= sig_i;
            sync_b   <= sync_a;
            last_lvl <= sync_b;
            primed   <= {primed[1:0], 1'b1};
        end
    end

    // Count edges only once the history flop holds real samples.
    assign edge_seen = primed[2] & (sync_b ^ last_lvl);

    // Idle counter and activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            active_o <= 1'b0;
        end else if (edge_seen) begin
            idle_cnt <= '0;
            active_o <= 1'b1;
        end else if (idle_cnt == LIMIT) begin
            active_o <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pair_select.sv
// Module: pair_select
// Registered two-way chooser. If only one candidate is present, that one
// is chosen. A tie goes to prio_i, and force_i makes the result prio_i.
// With no candidate present and no force, the last choice is held.
// Assumes: candidate flags are synchronous to clk.
module pair_select
    import sync_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  first_i,
    input  logic  second_i,
    input  logic  prio_i,
    input  logic  force_i,
    output pick_e sel_o
);
    pick_e sel_next;

    // Next choice from force, tie, one-sided and hold cases.
    always_comb begin
        if (force_i || (first_i && second_i)) begin
            sel_next = pick_e'(prio_i);
        end else if (second_i) begin
            sel_next = PICK_SECOND;
        end else if (first_i) begin
            sel_next = PICK_FIRST;
        end else begin
            sel_next = sel_o;
        end
    end

    // Choice register.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_o <= PICK_FIRST;
        else        sel_o <= sel_next;
    end
endmodule

// File: rtl/sync_arbiter.sv
// Module: sync_arbiter (top)
// Runs four activity monitors and two pair selectors. It also registers
// a seek request when neither interface is present and no force is set.
// Assumes: rst_n is synchronous to clk; the control bits are quasi-static.
module sync_arbiter
    import sync_arb_pkg::*;
#(
    parameter int IDLE_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_i,
    input  logic       sog_i,
    input  logic       vsync_i,
    input  logic       dclk_i,
    input  logic       if_prio_i,
    input  logic       if_force_i,
    input  logic       src_prio_i,
    input  logic       src_force_i,
    output logic [3:0] act_status_o,
    output logic       if_sel_o,
    output logic       sync_sel_o,
    output logic       seek_o
);
    logic [NUM_MON-1:0] mon_in;
    logic [NUM_MON-1:0] mon_act;
    logic               analog_seen;
    logic               digital_seen;
    pick_e              if_pick;
    pick_e              src_pick;

    // Place the monitored pins at their status positions.
    always_comb begin
        mon_in           = '0;
        mon_in[MON_HS]   = hsync_i;
        mon_in[MON_SOG]  = sog_i;
        mon_in[MON_VS]   = vsync_i;
        mon_in[MON_DCLK] = dclk_i;
    end

    // One monitor per watched input.
    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        activity_monitor #(.IDLE_LIMIT(IDLE_LIMIT)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_i    (mon_in[g]),
            .active_o (mon_act[g])
        );
    end

    assign analog_seen  = mon_act[MON_HS] | mon_act[MON_SOG] | mon_act[MON_VS];
    assign digital_seen = mon_act[MON_DCLK];

    // Interface choice: first = analog, second = digital.
    pair_select u_if_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .first_i  (analog_seen),
        .second_i (digital_seen),
        .prio_i   (if_prio_i),
        .force_i  (if_force_i),
        .sel_o    (if_pick)
    );

    // PLL sync source choice: first = sync pin, second = sync-on-green.
    pair_select u_src_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .first_i  (mon_act[MON_HS]),
        .second_i (mon_act[MON_SOG]),
        .prio_i   (src_prio_i),
        .force_i  (src_force_i),
        .sel_o    (src_pick)
    );

    // Seek request register.
    always_ff @(posedge clk) begin
        if (!rst_n) seek_o <= 1'b0;
        else        seek_o <= !if_force_i && !analog_seen && !digital_seen;
    end

    assign act_status_o = mon_act;
    assign if_sel_o     = if_pick;
    assign sync_sel_o   = src_pick;
endmodule

// File: rtl/sync_arbiter_checker.sv
// Module: sync_arbiter_checker
// Temporal checks on the ports of sync_arbiter, attached through bind.
// Assumes: an armed flag masks the first cycle after reset release.
module sync_arbiter_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       if_prio_i,
    input logic       if_force_i,
    input logic       src_prio_i,
    input logic       src_force_i,
    input logic [3:0] act_status_o,
    input logic       if_sel_o,
    input logic       sync_sel_o,
    input logic       seek_o
);
    logic armed;

    // Arm the checks one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_reset_zero_R12: assert property (@(posedge clk)
        !rst_n |=> (act_status_o == 4'b0 && !if_sel_o && !sync_sel_o && !seek_o));

    assert_analog_only_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!if_force_i && (|act_status_o[3:1]) && !act_status_o[0]) |-> !if_sel_o);

    assert_digital_only_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!if_force_i && act_status_o[3:1] == 3'b0 && act_status_o[0]) |-> if_sel_o);

    assert_if_tie_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!if_force_i && (|act_status_o[3:1]) && act_status_o[0])
        |-> if_sel_o == $past(if_prio_i));

    assert_seek_on_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!if_force_i && act_status_o == 4'b0) |-> (seek_o && $stable(if_sel_o)));

    assert_seek_off_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(if_force_i || act_status_o != 4'b0) |-> !seek_o);

    assert_if_force_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(if_force_i) |-> (if_sel_o == $past(if_prio_i) && !seek_o));

    assert_hs_only_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!src_force_i && act_status_o[3] && !act_status_o[2]) |-> !sync_sel_o);

    assert_sog_only_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!src_force_i && !act_status_o[3] && act_status_o[2]) |-> sync_sel_o);

    assert_src_prio_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(src_force_i || (act_status_o[3] && act_status_o[2]))
        |-> sync_sel_o == $past(src_prio_i));

    assert_src_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!src_force_i && !act_status_o[3] && !act_status_o[2]) |-> $stable(sync_sel_o));
endmodule

bind sync_arbiter sync_arbiter_checker u_chk (.*);

// File: tb/sync_arbiter_test.sv
module sync_arbiter_test;
    localparam int LIMIT = 64;
    localparam int QUIET = 3 * LIMIT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_i, sog_i, vsync_i, dclk_i;
    logic       if_prio_i = 1'b0, if_force_i = 1'b0;
    logic       src_prio_i = 1'b0, src_force_i = 1'b0;
    logic [3:0] act_status_o;
    logic       if_sel_o, sync_sel_o, seek_o;
    logic [3:0] tog_en = 4'b0;   // [3] hs, [2] sog, [1] vs, [0] dclk
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    sync_arbiter #(.IDLE_LIMIT(LIMIT)) uut (.*);

    // Toggler: flips enabled inputs every 4 cycles, holds the others.
    initial begin
        int ph;
        ph = 0;
        hsync_i = 1'b1; sog_i = 1'b1; vsync_i = 1'b1; dclk_i = 1'b1;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            if (ph == 0) begin
                if (tog_en[3]) hsync_i = ~hsync_i;
                if (tog_en[2]) sog_i   = ~sog_i;
                if (tog_en[1]) vsync_i = ~vsync_i;
                if (tog_en[0]) dclk_i  = ~dclk_i;
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_quiet();
        tog_en = 4'b0;
        wait_cyc(QUIET);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        check("R12 status", {4'b0, act_status_o}, 8'h0);
        check("R12 sel", {5'b0, if_sel_o, sync_sel_o, seek_o}, 8'h0);
        rst_n = 1'b1;
        wait_cyc(QUIET);
        check("R1 held inputs", {4'b0, act_status_o}, 8'h0);
        check("R7 seek", {7'b0, seek_o}, 8'h1);
    endtask

    task automatic t_hs_only();
        tog_en = 4'b1000;
        wait_cyc(20);
        check("R2 hs bit", {4'b0, act_status_o}, 8'h8);
        check("R4 analog", {7'b0, if_sel_o}, 8'h0);
        check("R9 hs src", {7'b0, sync_sel_o}, 8'h0);
        check("R7 no seek", {7'b0, seek_o}, 8'h0);
        wait_cyc(3 * LIMIT);
        check("R3 kept", {4'b0, act_status_o}, 8'h8);
        tog_en = 4'b0;
        wait_cyc(LIMIT / 2);
        check("R3 before timeout", {4'b0, act_status_o}, 8'h8);
        wait_cyc(LIMIT);
        check("R3 timed out", {4'b0, act_status_o}, 8'h0);
        wait_cyc(LIMIT);
    endtask

    task automatic t_sog_hold();
        tog_en = 4'b0100;
        wait_cyc(20);
        check("R2 sog bit", {4'b0, act_status_o}, 8'h4);
        check("R9 sog src", {7'b0, sync_sel_o}, 8'h1);
        check("R4 sog analog", {7'b0, if_sel_o}, 8'h0);
        go_quiet();
        check("R11 hold sog", {7'b0, sync_sel_o}, 8'h1);
        check("R7 hold if", {6'b0, if_sel_o, seek_o}, 8'h1);
    endtask

    task automatic t_vs_dclk();
        tog_en = 4'b0010;
        wait_cyc(20);
        check("R2 vs bit", {4'b0, act_status_o}, 8'h2);
        check("R11 vs keeps src", {7'b0, sync_sel_o}, 8'h1);
        tog_en = 4'b0001;
        wait_cyc(QUIET);
        check("R2 dclk bit", {4'b0, act_status_o}, 8'h1);
        check("R5 digital", {6'b0, if_sel_o, seek_o}, 8'h2);
        go_quiet();
        check("R7 hold digital", {6'b0, if_sel_o, seek_o}, 8'h3);
    endtask

    task automatic t_if_tie();
        tog_en = 4'b1001;
        if_prio_i = 1'b0;
        wait_cyc(20);
        check("R6 tie prio0", {7'b0, if_sel_o}, 8'h0);
        if_prio_i = 1'b1;
        wait_cyc(3);
        check("R6 tie prio1", {7'b0, if_sel_o}, 8'h1);
        if_prio_i = 1'b0;
        wait_cyc(3);
        check("R6 tie back", {7'b0, if_sel_o}, 8'h0);
        go_quiet();
    endtask

    task automatic t_if_force();
        if_force_i = 1'b1; if_prio_i = 1'b1;
        wait_cyc(3);
        check("R8 force quiet", {6'b0, if_sel_o, seek_o}, 8'h2);
        tog_en = 4'b1000;
        wait_cyc(20);
        check("R8 force over analog", {7'b0, if_sel_o}, 8'h1);
        if_prio_i = 1'b0;
        wait_cyc(3);
        check("R8 force prio0", {7'b0, if_sel_o}, 8'h0);
        if_force_i = 1'b0;
        go_quiet();
    endtask

    task automatic t_src_tie();
        tog_en = 4'b1100;
        src_prio_i = 1'b1;
        wait_cyc(20);
        check("R10 tie sog", {7'b0, sync_sel_o}, 8'h1);
        src_prio_i = 1'b0;
        wait_cyc(3);
        check("R10 tie hs", {7'b0, sync_sel_o}, 8'h0);
        tog_en = 4'b1000;
        src_force_i = 1'b1; src_prio_i = 1'b1;
        wait_cyc(QUIET);
        check("R10 force sog", {4'b0, act_status_o}, 8'h8);
        check("R10 force sel", {7'b0, sync_sel_o}, 8'h1);
        src_force_i = 1'b0;
        wait_cyc(3);
        check("R9 release to hs", {7'b0, sync_sel_o}, 8'h0);
        go_quiet();
        check("R11 hold hs", {7'b0, sync_sel_o}, 8'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hs_only();
        t_sog_hold();
        t_vs_dclk();
        t_if_tie();
        t_if_force();
        t_src_tie();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule